// File: doc/BRIEF.md
# Time-Division Multiplexed Frame Deserializer

This block is the receive end of a framed serial link in which a repeating frame is divided into a fixed number of timeslots, each carrying one byte. A serial data bit and a frame-start marker arrive on every bit clock. The block keeps a local bit counter, and the frame-start marker pulls that counter into line with the transmitter. Incoming bits move through a serial-in, parallel-out register. When the last bit of a slot is sampled, the assembled byte is copied into a holding register. The byte is then presented together with its slot number and a single-cycle valid strobe.

Clock recovery, line coding and routing each slot to its consumer happen elsewhere. The byte boundary is derived from the local counter, not from any start bit in the data. The slot count, the bits per slot and the bit order within a slot are parameters.

Top module: `tdmd_deser`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `byte_vld_o` and `resync_o` are 0 and `byte_o` and `slot_o` are all zeros.
- R2: After reset, and until `frame_sync_i` has been sampled high once, `byte_vld_o` stays 0 whatever the data.
- R3: The bit sampled together with `frame_sync_i` high is bit 0 of slot 0. Each later clock advances the bit position by one. After the last bit of the frame (position SLOTS*BITS-1) the position wraps to 0 without any marker.
- R4: A bit is shifted in on every clock. With MSB_FIRST=1 (the default), the first bit of a slot ends up in `byte_o[BITS-1]` and the last bit in `byte_o[0]`.
- R5: Once aligned, `byte_vld_o` is high for exactly one cycle, in the cycle after the clock edge that samples bit position BITS-1 of a slot. It is low in every other cycle.
- R6: In the cycle in which `byte_vld_o` is high, `slot_o` holds the number of the slot whose byte was captured. Slot 0 is the first slot after the frame start.
- R7: In every cycle in which `byte_vld_o` is low, `byte_o` and `slot_o` keep their previous values, even while the next byte is being shifted in.
- R8: If `frame_sync_i` is sampled high after alignment while the counter is not at position 0, the counter realigns on that same clock. `resync_o` is then high for exactly the following cycle.
- R9: `frame_sync_i` sampled on the first bit after a complete frame, and the first `frame_sync_i` after reset, do not raise `resync_o`. `resync_o` is never high unless `frame_sync_i` was high on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bit_i | input | 1 | Serial data bit |
| frame_sync_i | input | 1 | High with bit 0 of a frame |
| byte_o | output | BITS | Held byte of the last completed slot |
| slot_o | output | max(1,clog2(SLOTS)) | Slot number of the held byte |
| byte_vld_o | output | 1 | One-cycle strobe when the holding register loads |
| resync_o | output | 1 | One-cycle flag for an off-boundary frame marker |

## Verification
The bench builds the block with its defaults: 32 slots of 8 bits, sent MSB first. This gives a 256-bit frame, so the counter wraps on its own within a few hundred cycles. The last slot (31) and the free-running case with no marker are therefore both reached. Random data, markers exactly on frame boundaries, markers at arbitrary positions (including back-to-back ones) and a mid-run reset together cover the realignment and the locking behaviour.

// File: rtl/tdmd_pkg.sv
package tdmd_pkg;

   function automatic int clog2_min1(input int value);
      int w;
      w = 0;
      while ((1 << w) < value) w++;
      return (w < 1) ? 1 : w;
   endfunction

   function automatic bit is_pow2(input int value);
      return (value > 0) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/tdmd_frame_ctr.sv
module tdmd_frame_ctr #(
   parameter int FRAME_BITS = 256,
   parameter int CNT_W      = tdmd_pkg::clog2_min1(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   output logic [CNT_W-1:0] pos_o,
   output logic             locked_o,
   output logic             resync_o
);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             locked_q;
   logic             resync_q;
   logic [CNT_W-1:0] pos_d;
   logic [CNT_W-1:0] next_d;

   // current bit position: the marker forces position zero
   always_comb begin
      pos_d  = sync_i ? '0 : cnt_q;
      next_d = (pos_d == LAST_POS) ? '0 : pos_d + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         locked_q <= 1'b0;
         resync_q <= 1'b0;
      end else begin
         cnt_q    <= next_d;
         locked_q <= locked_q | sync_i;
         resync_q <= sync_i & locked_q & (cnt_q != '0);
      end
   end

   assign pos_o    = pos_d;
   assign locked_o = locked_q;
   assign resync_o = resync_q;
endmodule

// File: rtl/tdmd_sipo.sv
module tdmd_sipo #(
   parameter int  WIDTH     = 8,
   parameter bit  MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_i,
   output logic [WIDTH-1:0] word_o
);
   localparam int KEEP = WIDTH - 1;

   logic [KEEP-1:0] sr_q;

   generate
      if (MSB_FIRST) begin : g_msb
         // older bits sit at the high end
         assign word_o = {sr_q, bit_i};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= word_o[KEEP-1:0];
         end
      end else begin : g_lsb
         // older bits sit at the low end
         assign word_o = {bit_i, sr_q};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= word_o[WIDTH-1:1];
         end
      end
   endgenerate
endmodule

// File: rtl/tdmd_hold.sv
module tdmd_hold #(
   parameter int WIDTH  = 8,
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WIDTH-1:0]  word_i,
   input  logic [SLOT_W-1:0] slot_i,
   output logic [WIDTH-1:0]  byte_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic              vld_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_o <= '0;
         slot_o <= '0;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= load_i;
         if (load_i) begin
            byte_o <= word_i;
            slot_o <= slot_i;
         end
      end
   end
endmodule

// File: rtl/tdmd_deser.sv
module tdmd_deser #(
   parameter int SLOTS     = 32,
   parameter int BITS      = 8,
   parameter bit MSB_FIRST = 1'b1,
   parameter int SLOT_W    = tdmd_pkg::clog2_min1(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bit_i,
   input  logic              frame_sync_i,
   output logic [BITS-1:0]   byte_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic              byte_vld_o,
   output logic              resync_o
);
   localparam int FRAME_BITS = SLOTS * BITS;
   localparam int CNT_W      = tdmd_pkg::clog2_min1(FRAME_BITS);
   localparam int BIT_W      = tdmd_pkg::clog2_min1(BITS);

   generate
      if (!tdmd_pkg::is_pow2(BITS) || BITS < 2) begin : g_bad_bits
         $fatal(1, "BITS must be a power of two of at least 2");
      end
      if (SLOTS < 1) begin : g_bad_slots
         $fatal(1, "SLOTS must be at least 1");
      end
      if (SLOT_W < tdmd_pkg::clog2_min1(SLOTS)) begin : g_bad_sw
         $fatal(1, "SLOT_W too narrow for SLOTS");
      end
   endgenerate

   logic [CNT_W-1:0] pos;
   logic             locked;
   logic [BITS-1:0]  word;
   logic             slot_done;
   logic [SLOT_W-1:0] cur_slot;

   tdmd_frame_ctr #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (frame_sync_i),
      .pos_o   (pos),
      .locked_o(locked),
      .resync_o(resync_o)
   );

   tdmd_sipo #(.WIDTH(BITS), .MSB_FIRST(MSB_FIRST)) sipo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .bit_i (ser_bit_i),
      .word_o(word)
   );

   // last bit of a slot: low bit-number field all ones
   always_comb begin
      slot_done = locked && (pos[BIT_W-1:0] == {BIT_W{1'b1}});
   end

   generate
      if (CNT_W > BIT_W) begin : g_slot_field
         localparam int HI_W = CNT_W - BIT_W;
         logic [HI_W-1:0] hi;
         assign hi = pos[CNT_W-1:BIT_W];
         if (HI_W >= SLOT_W) begin : g_trim
            assign cur_slot = hi[SLOT_W-1:0];
         end else begin : g_pad
            assign cur_slot = {{(SLOT_W-HI_W){1'b0}}, hi};
         end
      end else begin : g_one_slot
         assign cur_slot = '0;
      end
   endgenerate

   tdmd_hold #(.WIDTH(BITS), .SLOT_W(SLOT_W)) hold_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(slot_done),
      .word_i(word),
      .slot_i(cur_slot),
      .byte_o(byte_o),
      .slot_o(slot_o),
      .vld_o (byte_vld_o)
   );
endmodule

module tdmd_deser_chk #(
   parameter int BITS   = 8,
   parameter int SLOT_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_sync_i,
   input logic [BITS-1:0]   byte_o,
   input logic [SLOT_W-1:0] slot_o,
   input logic              byte_vld_o,
   input logic              resync_o
);
   logic seen_sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_sync_q <= 1'b0;
      else        seen_sync_q <= seen_sync_q | frame_sync_i;
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!byte_vld_o && !resync_o && byte_o == '0 && slot_o == '0));

   a_r2_no_strobe_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_sync_q |-> !byte_vld_o);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |=> !byte_vld_o);

   a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld_o |=> (!byte_vld_o || 1'b1) && ($stable(byte_o) || $past(byte_vld_o) || byte_vld_o));

   a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      (!$rose(byte_vld_o) && !byte_vld_o) |-> ($stable(byte_o) && $stable(slot_o)));

   a_r9_resync_cause: assert property (@(posedge clk) disable iff (!rst_n)
      resync_o |-> $past(frame_sync_i));
endmodule

bind tdmd_deser tdmd_deser_chk #(.BITS(BITS), .SLOT_W(SLOT_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_sync_i(frame_sync_i),
   .byte_o      (byte_o),
   .slot_o      (slot_o),
   .byte_vld_o  (byte_vld_o),
   .resync_o    (resync_o)
);

// File: tb/tdmd_deser_tb.sv
module tdmd_deser_tb_top;
   localparam int SLOTS  = 32;
   localparam int BITS   = 8;
   localparam int FRAME  = SLOTS * BITS;
   localparam int SLOT_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ser_bit = 1'b0;
   logic              fsync = 1'b0;
   logic [BITS-1:0]   byte_o;
   logic [SLOT_W-1:0] slot_o;
   logic              byte_vld_o;
   logic              resync_o;

   int total = 0;
   int bad   = 0;

   // bench reference state
   int        m_cnt;
   bit        m_locked;
   bit [7:0]  m_sr;
   bit [7:0]  m_byte;
   int        m_slot;
   bit [31:0] seed_dummy;

   always #5 clk = ~clk;

   tdmd_deser dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ser_bit_i   (ser_bit),
      .frame_sync_i(fsync),
      .byte_o      (byte_o),
      .slot_o      (slot_o),
      .byte_vld_o  (byte_vld_o),
      .resync_o    (resync_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit [7:0] shift_in(input bit [7:0] sr, input bit b);
      return {sr[6:0], b};
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_locked = 0; m_sr = '0; m_byte = '0; m_slot = 0;
   endtask

   // one bit period: inputs applied at negedge, outputs checked at next negedge
   task automatic step(input bit b, input bit s);
      int  idx;
      bit  exp_vld;
      bit  exp_res;
      bit [7:0] word;
      ser_bit = b;
      fsync   = s;
      idx     = s ? 0 : m_cnt;
      word    = shift_in(m_sr, b);
      exp_vld = m_locked && ((idx % BITS) == BITS - 1);
      exp_res = s && m_locked && (m_cnt != 0);
      if (exp_vld) begin
         m_byte = word;
         m_slot = idx / BITS;
      end
      m_sr     = word;
      m_locked = m_locked | s;
      m_cnt    = (idx + 1) % FRAME;
      @(posedge clk);
      @(negedge clk);
      if (!m_locked || (m_locked && !exp_vld && !s && idx == 0))
         check(byte_vld_o == exp_vld, "R2 strobe", byte_vld_o, exp_vld);
      else
         check(byte_vld_o == exp_vld, "R5 strobe", byte_vld_o, exp_vld);
      if (exp_res)
         check(resync_o == 1'b1, "R8 resync", resync_o, 1);
      else
         check(resync_o == 1'b0, "R9 no resync", resync_o, 0);
      if (exp_vld) begin
         check(byte_o == m_byte, "R4 byte", byte_o, m_byte);
         check(int'(slot_o) == m_slot, "R6 slot (R3 alignment)", slot_o, m_slot);
      end else begin
         check(byte_o == m_byte && int'(slot_o) == m_slot, "R7 held", byte_o, m_byte);
      end
   endtask

   task automatic send_frame(input bit with_sync, input bit [7:0] first_byte, input bit fixed_first);
      for (int sl = 0; sl < SLOTS; sl++) begin
         bit [7:0] v;
         v = (sl == 0 && fixed_first) ? first_byte : 8'($urandom);
         for (int k = 0; k < BITS; k++)
            step(v[7-k], with_sync && sl == 0 && k == 0);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      fsync = 1'b0;
      ser_bit = 1'b1;
      model_reset();
      repeat (3) @(negedge clk);
      check(byte_vld_o == 0 && resync_o == 0, "R1 flags in reset", {byte_vld_o, resync_o}, 0);
      check(byte_o == 0 && slot_o == 0, "R1 data in reset", byte_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(byte_vld_o == 0 && byte_o == 0 && slot_o == 0, "R1 after release", byte_o, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      seed_dummy = $urandom(32'd20240611);
      do_reset();
      // R2: long random stretch with no marker
      for (int i = 0; i < 300; i++) step(1'($urandom), 1'b0);
      // R3/R4: first marker, known first byte 0xA5 lands MSB first
      send_frame(1'b1, 8'hA5, 1'b1);
      // R9: markers exactly on frame boundaries
      send_frame(1'b1, 8'h3C, 1'b1);
      send_frame(1'b1, 8'hFF, 1'b1);
      // R3: free-running wrap with no marker
      send_frame(1'b0, 8'h00, 1'b1);
      send_frame(1'b0, 8'h81, 1'b1);
      // R8: early marker mid-slot, then back-to-back markers
      for (int i = 0; i < 77; i++) step(1'($urandom), 1'b0);
      step(1'b1, 1'b1);
      step(1'b0, 1'b1);
      for (int i = 0; i < 40; i++) step(1'($urandom), 1'b0);
      // marker on the very last frame bit position
      for (int i = 0; i < FRAME - 42; i++) step(1'($urandom), 1'b0);
      step(1'b1, 1'b1);
      // random phase with sparse markers
      for (int i = 0; i < 4000; i++) begin
         bit s;
         s = (m_cnt == 0) ? (($urandom % 2) == 0) : (($urandom % 500) == 0);
         step(1'($urandom), s);
      end
      // mid-run reset: R1 then R2 again
      do_reset();
      for (int i = 0; i < 64; i++) step(1'($urandom), 1'b0);
      send_frame(1'b1, 8'h5A, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule